// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer with Overdrive Speed Control

This block sits above the bit-level engine of a single-wire bus slave. The engine below it detects reset pulses and reports whether each one was long or short. It also delivers each received command byte and each address bit as a one-cycle strobe. This layer turns that stream into two outputs: a `selected_o` flag that lets the memory function layer run, and an `od_o` flag that tells the timing layer to use the fast slot timing.

Two addressing commands are supported. The overdrive skip code `0x3C` selects the device at once and switches it to fast speed. The overdrive match code `0x69` also switches to fast speed, and is then followed by a 64-bit address. The address is checked bit by bit against the device's own identity, `DEV_ID`. If every bit agrees, the device is selected. At the first bit that differs, the device drops out and waits for the next reset. On that drop-out it restores the speed flag it had before the match began.

Every other command code also sends the block to the wait-for-reset state. On a shared bus, slaves that are selected together by a skip simply drive the line at the same time. The line then gives the wired-AND of their bits, and this layer does not arbitrate.

Top module: `owire_rom_layer`

## Requirements
- R1: After `rst_n` is released, `selected_o`=0 and `od_o`=0. Command bytes and address bits are ignored until the first bus reset strobe.
- R2: In the command phase that follows a bus reset, byte `0x3C` sets `selected_o`=1 and `od_o`=1 in the cycle after the byte strobe.
- R3: In the command phase, byte `0x69` sets `od_o`=1 in the next cycle. Each following bit strobe with index i (0 to 63, i=0 first) is compared with `DEV_ID[i]`. If all 64 bits agree, `selected_o` rises in the cycle after the 64th bit strobe.
- R4: On an address bit that does not agree, `od_o` returns to the value it had before the `0x69` byte and `selected_o` stays 0. Later bytes and bits are ignored until a bus reset.
- R5: The compare stops at the first bit that does not agree. Address bits received after that bit never select the device.
- R6: A bus reset strobe with `rst_long_i`=1 clears `od_o`. A bus reset strobe with `rst_long_i`=0 leaves `od_o` unchanged.
- R7: Every bus reset strobe clears `selected_o` in the next cycle and returns the block to the command phase.
- R8: Any command byte other than `0x3C` or `0x69` sends the block to the wait-for-reset state. In that state a later `0x3C` does not select the device.
- R9: While the device is selected, further byte and bit strobes leave `selected_o` and `od_o` unchanged.
- R10: A bus reset strobe takes priority over a byte or bit strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rst_i | input | 1 | One-cycle strobe: a bus reset pulse was detected |
| rst_long_i | input | 1 | The reset pulse was long (regular-speed length), valid with `bus_rst_i` |
| byte_vld_i | input | 1 | One-cycle strobe: a command byte is valid |
| byte_i | input | 8 | Received command byte |
| bit_vld_i | input | 1 | One-cycle strobe: an address bit is valid |
| bit_i | input | 1 | Received address bit |
| selected_o | output | 1 | Device is addressed; memory functions allowed |
| od_o | output | 1 | Fast (overdrive) bus timing in effect |

## Verification
The match command is tried with the exact identity, and with a single flipped bit at the first position, the last position and random positions. These cases separate a full compare from one that checks only part of the address or selects on the final bit. Mismatches are sent both from regular speed and from an already-fast device, which shows whether the speed flag is restored rather than simply cleared. Long and short resets are mixed with skip commands, unknown codes and stray strobes. This shows whether the speed flag and the wait state respond to the reset length alone. Reset strobes that land together with bytes or bits test which input takes priority.

// File: rtl/owire_rom_layer.sv
module owire_rom_layer #(
  parameter int          ADDR_BITS = 64,
  parameter logic [63:0] DEV_ID    = 64'hC3A5_0017_2B94_E601,
  parameter logic [7:0]  CMD_SKIP  = 8'h3C,
  parameter logic [7:0]  CMD_MATCH = 8'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst_i,
  input  logic       rst_long_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  output logic       selected_o,
  output logic       od_o
);
  localparam int CW = $clog2(ADDR_BITS);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BITS - 1);

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_SEL, PH_WAIT} phase_t;

  phase_t        phase;
  logic [CW-1:0] idx;
  logic          od_keep;

  wire id_bit = DEV_ID[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_WAIT;
      idx     <= '0;
      od_o    <= 1'b0;
      od_keep <= 1'b0;
    end else if (bus_rst_i) begin
      phase <= PH_CMD;
      if (rst_long_i) od_o <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: if (byte_vld_i) begin
          if (byte_i == CMD_SKIP) begin
            phase <= PH_SEL;
            od_o  <= 1'b1;
          end else if (byte_i == CMD_MATCH) begin
            phase   <= PH_ADDR;
            od_keep <= od_o;
            od_o    <= 1'b1;
            idx     <= '0;
          end else begin
            phase <= PH_WAIT;
          end
        end
        PH_ADDR: if (bit_vld_i) begin
          if (bit_i != id_bit) begin
            phase <= PH_WAIT;
            od_o  <= od_keep;
          end else if (idx == LAST) begin
            phase <= PH_SEL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign selected_o = (phase == PH_SEL);
endmodule

// File: rtl/owire_rom_layer_chk.sv
module owire_rom_layer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rst_i,
  input logic rst_long_i,
  input logic byte_vld_i,
  input logic bit_vld_i,
  input logic selected_o,
  input logic od_o
);
  a_r7_reset_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> !selected_o);
  a_r6_long_clears_od: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i && rst_long_i |=> !od_o);
  a_r6_short_keeps_od: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i && !rst_long_i && od_o |=> od_o);
  a_r3_sel_means_fast: assert property (@(posedge clk) disable iff (!rst_n)
    selected_o |-> od_o);
  a_r9_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    selected_o && !bus_rst_i |=> selected_o && od_o);
  a_r2_sel_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> $past(byte_vld_i || bit_vld_i));
endmodule

bind owire_rom_layer owire_rom_layer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .rst_long_i(rst_long_i),
  .byte_vld_i(byte_vld_i), .bit_vld_i(bit_vld_i),
  .selected_o(selected_o), .od_o(od_o)
);

// File: tb/owire_rom_layer_bench.sv
module owire_rom_layer_bench;
  localparam logic [63:0] ID = 64'h9E21_47D0_05BC_3A6F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_i = 0, rst_long_i = 0, byte_vld_i = 0, bit_vld_i = 0, bit_i = 0;
  logic [7:0] byte_i = 8'h00;
  logic selected_o, od_o;

  int total = 0, bad = 0;
  int ph = 3, idx = 0;
  logic m_od = 0, m_keep = 0;

  always #5 clk = ~clk;

  owire_rom_layer #(.DEV_ID(ID)) u_owire_rom_layer (.*);

  task automatic check(input string tag, input logic exp_sel, input logic exp_od);
    total++;
    if (selected_o !== exp_sel || od_o !== exp_od) begin
      bad++;
      $display("FAIL %s: sel=%b od=%b expected sel=%b od=%b", tag, selected_o, od_o, exp_sel, exp_od);
    end
  endtask

  task automatic step(input logic rs, input logic rl, input logic bv, input logic [7:0] b,
                      input logic tv, input logic t, input string tag);
    @(negedge clk);
    bus_rst_i = rs; rst_long_i = rl; byte_vld_i = bv; byte_i = b; bit_vld_i = tv; bit_i = t;
    @(negedge clk);
    bus_rst_i = 0; rst_long_i = 0; byte_vld_i = 0; bit_vld_i = 0;
    if (rs) begin
      ph = 0;
      if (rl) m_od = 0;
    end else if (bv && ph == 0) begin
      if (b == 8'h3C) begin ph = 2; m_od = 1; end
      else if (b == 8'h69) begin ph = 1; m_keep = m_od; m_od = 1; idx = 0; end
      else ph = 3;
    end else if (tv && ph == 1) begin
      if (t != ID[idx]) begin ph = 3; m_od = m_keep; end
      else if (idx == 63) ph = 2;
      else idx++;
    end
    check(tag, ph == 2, m_od);
  endtask

  task automatic bus_reset(input logic lng, input string tag);
    step(1, lng, 0, 8'h00, 0, 0, tag);
  endtask
  task automatic cmd(input logic [7:0] b, input string tag);
    step(0, 0, 1, b, 0, 0, tag);
  endtask
  task automatic addr(input int flip, input string tag);
    for (int i = 0; i < 64; i++) step(0, 0, 0, 8'h00, 1, ID[i] ^ (i == flip), tag);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int r;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", 0, 0);
    cmd(8'h3C, "R1 byte before bus reset");
    addr(-1, "R1 bits before bus reset");

    bus_reset(1, "R7 first reset");
    cmd(8'h3C, "R2 skip selects");
    cmd(8'h69, "R9 byte while selected");
    step(0, 0, 0, 8'h00, 1, 1, "R9 bit while selected");
    bus_reset(0, "R6 short keeps od");
    bus_reset(1, "R6 long clears od");

    cmd(8'h69, "R3 match sets od");
    addr(-1, "R3 full match");
    bus_reset(1, "R7 deselect");
    cmd(8'h69, "R4 match from slow");
    addr(0, "R4 first bit wrong");
    cmd(8'h3C, "R4 ignored after mismatch");
    bus_reset(0, "R6 short while slow");
    cmd(8'h3C, "R2 skip");
    bus_reset(0, "R7 short reset deselects");
    cmd(8'h69, "R4 match from fast");
    addr(63, "R5 last bit wrong");
    bus_reset(1, "R6 long");
    cmd(8'h69, "R5 match");
    addr(17, "R5 mid bit wrong, later bits ignored");
    bus_reset(1, "R6 long");
    cmd(8'hF0, "R8 unknown code");
    cmd(8'h3C, "R8 skip after unknown ignored");
    bus_reset(1, "R7 reset");
    step(1, 1, 1, 8'h3C, 0, 0, "R10 reset beats byte");
    cmd(8'h69, "R3 match");
    step(1, 0, 0, 8'h00, 1, ID[0], "R10 reset beats bit");

    for (int n = 0; n < 300; n++) begin
      r = $urandom_range(0, 9);
      case (r)
        0: bus_reset(1, "R6 random long reset");
        1: bus_reset(0, "R6 random short reset");
        2, 3: cmd(8'h3C, "R2 random skip");
        4, 5: cmd(8'h69, "R3 random match");
        6: begin
          b = 8'($urandom);
          cmd(b, "R8 random code");
        end
        7: addr(-1, "R3 random full address");
        8: addr($urandom_range(0, 63), "R5 random flipped bit");
        default: step(0, 0, 0, 8'h00, 1, 1'($urandom), "R9 random stray bit");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule